// File: doc/BRIEF.md
# SPI Target Register Bridge

This block lets an external SPI host reach a 32-bit register space inside the chip. The host holds chip select low and clocks whole 32-bit words in SPI mode 0, most significant bit first. The first word of a frame is a command. The command names a byte address, a direction, whether the address steps between words, and a word count. The data words for that command follow it. Further commands may come after those data words within the same chip-select frame.

Write data is placed on a simple synchronous bus with a one-cycle write strobe. Read data is fetched over the same bus, or from a small identification ROM inside the block, and shifted back on MISO in the slot that follows. Every slot that carries no read data returns a fixed filler pattern, so the host can recognise that a target is present.

The SPI pins are synchronised into the system clock domain. All decoding and bus traffic run on the system clock.

Top module: `spi_regbridge`

## Requirements
- R1: SPI mode 0, MSB first, 32-bit words: MOSI is taken on each rising SCLK edge, and MISO changes only after falling edges. SCLK must stay high and low for at least 5 system clocks each.
- R2: Command word fields: bits 31:16 are the byte address, bits 15:12 the opcode, bit 11 the increment flag, bits 10:4 the word count (0 to 127). Bits 3:0 are ignored.
- R3: Opcode 0xA reads. Each of the next N slots returns on MISO the word at the current address. Opcode 0xB writes. Each of the next N words is driven on the bus with a single-cycle `bus_we`.
- R4: With the increment flag set, the address grows by 4 after each data word, wrapping within 16 bits. With the flag clear, every data word uses the command's address.
- R5: A command whose opcode is neither 0xA nor 0xB, or whose count is 0, produces no bus strobe. The word that follows it is decoded as a command.
- R6: Any number of commands with their data words may follow one another in one chip-select frame.
- R7: Reads of 0x100, 0x104, 0x108 and 0x10C return 0x55AACAFE, 0x54534F48, 0x32544F4D and 0x00000400. Reads of 0x40C and 0x410 return the two ASCII identifier parameters. These reads never assert `bus_re`.
- R8: MISO carries 0xAAAAAAAA in every slot that is not a read-data slot. This includes the first word of each frame.
- R9: Raising chip select aborts any command in progress and discards a partly received word. The next frame begins with a command word.
- R10: A read asserts `bus_re` for one cycle with `bus_addr` valid. `bus_rdata` is taken in the following cycle. Each non-ROM read slot causes exactly one `bus_re`.
- R11: During and after reset, `spi_miso`, `bus_we` and `bus_re` are low. MISO stays low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock from the host |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| bus_addr | output | 16 | Register byte address |
| bus_wdata | output | 32 | Register write data |
| bus_we | output | 1 | Write strobe, one cycle per word |
| bus_re | output | 1 | Read strobe, one cycle per word |
| bus_rdata | input | 32 | Read data, valid the cycle after `bus_re` |

## Verification
A wrong bit count or a wrong decoder state shows up at the very next word boundary. The decoder may treat a data word as a command, or a command as data. The result is a write to an address nobody asked for, a missing write, or a read slot that returns filler instead of data. A wrong address step or a missed fetch appears as a wrong MISO word in the slot right after the command, about one word time after the fault. The bench therefore compares every MISO word and every bus write against queued expectations, across chained commands, ignored commands and an aborted frame.

// File: rtl/srb_pkg.sv
package srb_pkg;

    localparam int WORD_W  = 32;
    localparam int ADDR_W  = 16;
    localparam int COUNT_W = 7;

    localparam logic [WORD_W-1:0] FILL_WORD = 32'hAAAA_AAAA;
    localparam logic [3:0]        OP_READ   = 4'hA;
    localparam logic [3:0]        OP_WRITE  = 4'hB;
    localparam logic [ADDR_W-1:0] ADDR_STEP = 16'd4;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_READ,
        ENG_WRITE
    } eng_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0]  addr;
        logic [3:0]         op;
        logic               inc;
        logic [COUNT_W-1:0] count;
        logic [3:0]         rsvd;
    } cmd_word_t;

    function automatic cmd_word_t unpack_cmd(input logic [WORD_W-1:0] w);
        return cmd_word_t'(w);
    endfunction

endpackage

// File: rtl/srb_spi_phy.sv
module srb_spi_phy
    import srb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    input  logic [WORD_W-1:0] tx_next,
    output logic              spi_miso,
    output logic              cs_act,
    output logic              word_done,
    output logic [WORD_W-1:0] rx_word
);
    localparam int SMSB  = SYNC_STAGES - 1;
    localparam int CNT_W = $clog2(WORD_W);

    logic [SMSB:0]      sclk_sync, cs_sync, mosi_sync;
    logic               sclk_d, cs_act_d;
    logic [CNT_W-1:0]   bit_cnt;
    logic [WORD_W-1:0]  rx_sr, tx_sr;
    logic               sclk_q, mosi_q, rise, fall, cs_start;
    logic [WORD_W-1:0]  rx_shifted;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_sync <= '0;
            cs_sync   <= '1;
            mosi_sync <= '0;
        end else begin
            sclk_sync <= {sclk_sync[SMSB-1:0], spi_sclk};
            cs_sync   <= {cs_sync[SMSB-1:0], spi_cs_n};
            mosi_sync <= {mosi_sync[SMSB-1:0], spi_mosi};
        end
    end

    assign sclk_q     = sclk_sync[SMSB];
    assign mosi_q     = mosi_sync[SMSB];
    assign cs_act     = ~cs_sync[SMSB];
    assign rise       = sclk_q & ~sclk_d;
    assign fall       = ~sclk_q & sclk_d;
    assign cs_start   = cs_act & ~cs_act_d;
    assign rx_shifted = {rx_sr[WORD_W-2:0], mosi_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d    <= 1'b0;
            cs_act_d  <= 1'b0;
            bit_cnt   <= '0;
            rx_sr     <= '0;
            tx_sr     <= '0;
            rx_word   <= '0;
            word_done <= 1'b0;
        end else begin
            sclk_d    <= sclk_q;
            cs_act_d  <= cs_act;
            word_done <= 1'b0;
            if (!cs_act) begin
                bit_cnt <= '0;
                tx_sr   <= '0;
            end else if (cs_start) begin
                bit_cnt <= '0;
                tx_sr   <= FILL_WORD;
            end else begin
                if (rise) begin
                    rx_sr   <= rx_shifted;
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == CNT_W'(WORD_W - 1)) begin
                        word_done <= 1'b1;
                        rx_word   <= rx_shifted;
                    end
                end
                if (fall) begin
                    tx_sr <= (bit_cnt == '0) ? tx_next : {tx_sr[WORD_W-2:0], 1'b0};
                end
            end
        end
    end

    assign spi_miso = tx_sr[WORD_W-1];

    // R8: each frame opens with the filler word loaded for shifting
    a_r8_frame_filler: assert property (@(posedge clk) disable iff (rst)
        cs_start |=> (tx_sr == FILL_WORD));

    // R9: complete words are only reported inside an active frame
    a_r9_word_in_frame: assert property (@(posedge clk) disable iff (rst)
        word_done |-> cs_act_d);

    // R11: MISO is quiet once chip select has been seen inactive
    a_r11_idle_miso: assert property (@(posedge clk) disable iff (rst)
        (!cs_act && !cs_act_d) |=> !spi_miso);

endmodule

// File: rtl/srb_id_rom.sv
module srb_id_rom
    import srb_pkg::*;
#(
    parameter logic [WORD_W-1:0] ID_WORD0 = 32'h5342_5247,
    parameter logic [WORD_W-1:0] ID_WORD1 = 32'h3130_5256
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [WORD_W-1:0] value
);
    always_comb begin
        hit   = 1'b1;
        value = '0;
        case (addr)
            16'h0100: value = 32'h55AA_CAFE;
            16'h0104: value = 32'h5453_4F48;
            16'h0108: value = 32'h3254_4F4D;
            16'h010C: value = 32'h0000_0400;
            16'h040C: value = ID_WORD0;
            16'h0410: value = ID_WORD1;
            default:  hit   = 1'b0;
        endcase
    end
endmodule

// File: rtl/srb_cmd_engine.sv
module srb_cmd_engine
    import srb_pkg::*;
#(
    parameter logic [WORD_W-1:0] ID_WORD0 = 32'h5342_5247,
    parameter logic [WORD_W-1:0] ID_WORD1 = 32'h3130_5256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_act,
    input  logic              word_done,
    input  logic [WORD_W-1:0] rx_word,
    input  logic [WORD_W-1:0] bus_rdata,
    output logic [WORD_W-1:0] tx_next,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    output logic              bus_we,
    output logic              bus_re
);
    eng_state_e         st;
    logic [ADDR_W-1:0]  cur_addr, addr_after, fetch_addr;
    logic [COUNT_W-1:0] remain;
    logic               inc_q, fetch_s1, fetch_s2, rom_sel_q, do_fetch, rom_hit;
    logic [WORD_W-1:0]  rom_val_q, rom_val;
    cmd_word_t          cmd;
    logic               unused_rsvd;

    assign cmd         = unpack_cmd(rx_word);
    assign unused_rsvd = ^cmd.rsvd;
    assign addr_after  = cur_addr + (inc_q ? ADDR_STEP : '0);

    always_comb begin
        do_fetch   = 1'b0;
        fetch_addr = addr_after;
        if (st == ENG_IDLE) begin
            do_fetch   = (cmd.op == OP_READ) && (cmd.count != '0);
            fetch_addr = cmd.addr;
        end else if (st == ENG_READ) begin
            do_fetch   = (remain > COUNT_W'(1));
        end
    end

    srb_id_rom #(.ID_WORD0(ID_WORD0), .ID_WORD1(ID_WORD1)) u_rom (
        .addr  (fetch_addr),
        .hit   (rom_hit),
        .value (rom_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ENG_IDLE;
            cur_addr  <= '0;
            remain    <= '0;
            inc_q     <= 1'b0;
            fetch_s1  <= 1'b0;
            fetch_s2  <= 1'b0;
            rom_sel_q <= 1'b0;
            rom_val_q <= '0;
            tx_next   <= FILL_WORD;
            bus_addr  <= '0;
            bus_wdata <= '0;
            bus_we    <= 1'b0;
            bus_re    <= 1'b0;
        end else begin
            bus_we   <= 1'b0;
            bus_re   <= 1'b0;
            fetch_s1 <= 1'b0;
            fetch_s2 <= fetch_s1;
            if (word_done) begin
                tx_next <= FILL_WORD;
                if (do_fetch) begin
                    fetch_s1  <= 1'b1;
                    bus_re    <= ~rom_hit;
                    bus_addr  <= fetch_addr;
                    rom_sel_q <= rom_hit;
                    rom_val_q <= rom_val;
                end
                case (st)
                    ENG_IDLE: begin
                        if (cmd.count != '0 && (cmd.op == OP_READ || cmd.op == OP_WRITE)) begin
                            st       <= (cmd.op == OP_READ) ? ENG_READ : ENG_WRITE;
                            cur_addr <= cmd.addr;
                            remain   <= cmd.count;
                            inc_q    <= cmd.inc;
                        end
                    end
                    ENG_READ: begin
                        remain   <= remain - 1'b1;
                        cur_addr <= addr_after;
                        if (remain == COUNT_W'(1)) st <= ENG_IDLE;
                    end
                    ENG_WRITE: begin
                        bus_we    <= 1'b1;
                        bus_addr  <= cur_addr;
                        bus_wdata <= rx_word;
                        remain    <= remain - 1'b1;
                        cur_addr  <= addr_after;
                        if (remain == COUNT_W'(1)) st <= ENG_IDLE;
                    end
                    default: st <= ENG_IDLE;
                endcase
            end else if (!cs_act) begin
                st     <= ENG_IDLE;
                remain <= '0;
            end
            if (fetch_s2) tx_next <= rom_sel_q ? rom_val_q : bus_rdata;
        end
    end

    // R3: an open burst always has words left to move
    a_r3_count_live: assert property (@(posedge clk) disable iff (rst)
        (st != ENG_IDLE) |-> (remain != '0));

    // R10: strobes are single-cycle pulses
    a_r10_we_pulse: assert property (@(posedge clk) disable iff (rst)
        bus_we |=> !bus_we);
    a_r10_re_pulse: assert property (@(posedge clk) disable iff (rst)
        bus_re |=> !bus_re);

    // R9: chip select going away drops the decoder back to command
    a_r9_abort_idle: assert property (@(posedge clk) disable iff (rst)
        (!cs_act && !word_done) |=> (st == ENG_IDLE));

    // R5: strobes never overlap
    a_r5_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_re));

endmodule

// File: rtl/spi_regbridge.sv
module spi_regbridge
    import srb_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [WORD_W-1:0] ID_WORD0    = 32'h5342_5247,
    parameter logic [WORD_W-1:0] ID_WORD1    = 32'h3130_5256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        spi_sclk,
    input  logic        spi_cs_n,
    input  logic        spi_mosi,
    output logic        spi_miso,
    output logic [15:0] bus_addr,
    output logic [31:0] bus_wdata,
    output logic        bus_we,
    output logic        bus_re,
    input  logic [31:0] bus_rdata
);
    logic              cs_act, word_done;
    logic [WORD_W-1:0] rx_word, tx_next;

    srb_spi_phy #(.SYNC_STAGES(SYNC_STAGES)) u_phy (
        .clk       (clk),
        .rst       (rst),
        .spi_sclk  (spi_sclk),
        .spi_cs_n  (spi_cs_n),
        .spi_mosi  (spi_mosi),
        .tx_next   (tx_next),
        .spi_miso  (spi_miso),
        .cs_act    (cs_act),
        .word_done (word_done),
        .rx_word   (rx_word)
    );

    srb_cmd_engine #(.ID_WORD0(ID_WORD0), .ID_WORD1(ID_WORD1)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .cs_act    (cs_act),
        .word_done (word_done),
        .rx_word   (rx_word),
        .bus_rdata (bus_rdata),
        .tx_next   (tx_next),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re)
    );
endmodule

// File: tb/spi_regbridge_bench.sv
module spi_regbridge_bench;
    localparam int          CLK_PERIOD = 10;
    localparam int          HALF       = 6;
    localparam logic [31:0] FILL       = 32'hAAAA_AAAA;
    localparam logic [31:0] ID0        = 32'h5342_5247;
    localparam logic [31:0] ID1        = 32'h3130_5256;

    logic        clk = 1'b0, rst = 1'b1;
    logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic        miso, bus_we, bus_re;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;

    int n_checks = 0, n_fail = 0, re_count = 0;

    spi_regbridge u_spi_regbridge (
        .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] seed(input int idx);
        return {16'hC0DE, 8'h00, 8'(idx)};
    endfunction

    // register slave behind the bus: read data one cycle after bus_re
    logic [31:0] slave_mem [256];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) slave_mem[i] <= seed(i);
            bus_rdata <= '0;
        end else begin
            if (bus_we) slave_mem[bus_addr[9:2]] <= bus_wdata;
            if (bus_re) bus_rdata <= slave_mem[bus_addr[9:2]];
        end
    end

    logic [31:0] shadow [256];
    logic [31:0] exp_d[$], wq_a[$], wq_d[$];
    string       exp_t[$], wq_t[$];
    logic [31:0] rx_got;
    event        word_ev;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_rd(input logic [15:0] a);
        case (a)
            16'h0100: return 32'h55AA_CAFE;
            16'h0104: return 32'h5453_4F48;
            16'h0108: return 32'h3254_4F4D;
            16'h010C: return 32'h0000_0400;
            16'h040C: return ID0;
            16'h0410: return ID1;
            default:  return shadow[a[9:2]];
        endcase
    endfunction

    function automatic logic [31:0] mk_cmd(input logic [3:0] op, input logic [15:0] a,
                                           input bit inc, input int cnt);
        return {a, op, inc, 7'(cnt), 4'h0};
    endfunction

    // scoreboard monitor for MISO words
    initial forever begin
        @(word_ev);
        if (exp_d.size() == 0) begin
            check(1'b0, "R8 unexpected word", rx_got, 32'h0);
        end else begin
            logic [31:0] e;
            string       t;
            e = exp_d.pop_front();
            t = exp_t.pop_front();
            check(rx_got === e, t, rx_got, e);
        end
    end

    // scoreboard monitor for bus writes
    always @(negedge clk) begin
        if (!rst && bus_re) re_count++;
        if (!rst && bus_we) begin
            if (wq_a.size() == 0) begin
                check(1'b0, "R5 unexpected write", {16'h0, bus_addr}, 32'h0);
            end else begin
                logic [31:0] ea, ed;
                string       t;
                ea = wq_a.pop_front();
                ed = wq_d.pop_front();
                t  = wq_t.pop_front();
                check({16'h0, bus_addr} === ea, {t, " addr"}, {16'h0, bus_addr}, ea);
                check(bus_wdata === ed, {t, " data"}, bus_wdata, ed);
            end
        end
    end

    task automatic shift_word(input logic [31:0] tx, input int nbits);
        logic [31:0] got;
        got = '0;
        for (int b = 31; b >= 32 - nbits; b--) begin
            mosi = tx[b];
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
            got  = {got[30:0], miso};
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        if (nbits == 32) begin
            rx_got = got;
            ->word_ev;
        end
    endtask

    task automatic xfer(input logic [31:0] tx, input logic [31:0] e, input string tag);
        exp_d.push_back(e);
        exp_t.push_back(tag);
        shift_word(tx, 32);
    endtask

    task automatic begin_frame();
        @(negedge clk);
        cs_n = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic end_frame();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic do_read(input logic [15:0] a, input bit inc, input int cnt, input string tag);
        logic [15:0] cur;
        cur = a;
        xfer(mk_cmd(4'hA, a, inc, cnt), FILL, "R8 filler on command slot");
        for (int k = 0; k < cnt; k++) begin
            // MOSI carries a write-like pattern that must be ignored in read slots
            xfer(mk_cmd(4'hB, 16'h0000, 1'b1, 1), model_rd(cur), tag);
            if (inc) cur = cur + 16'd4;
        end
    endtask

    task automatic do_write(input logic [15:0] a, input bit inc, input int cnt,
                            input logic [31:0] base, input string tag);
        logic [15:0] cur;
        cur = a;
        xfer(mk_cmd(4'hB, a, inc, cnt), FILL, "R8 filler on command slot");
        for (int k = 0; k < cnt; k++) begin
            logic [31:0] d;
            d = base + 32'(k) * 32'h0101_0101;
            wq_a.push_back({16'h0, cur});
            wq_d.push_back(d);
            wq_t.push_back(tag);
            shadow[cur[9:2]] = d;
            xfer(d, FILL, "R8 filler on write slot");
            if (inc) cur = cur + 16'd4;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 32'h0, 32'h0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int re0;
        for (int i = 0; i < 256; i++) shadow[i] = seed(i);
        repeat (4) @(negedge clk);
        check(miso == 1'b0 && bus_we == 1'b0 && bus_re == 1'b0, "R11 outputs in reset",
              {29'h0, miso, bus_we, bus_re}, 32'h0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check(miso == 1'b0 && bus_we == 1'b0 && bus_re == 1'b0, "R11 outputs after reset",
              {29'h0, miso, bus_we, bus_re}, 32'h0);

        // identification words from the built-in ROM, MSB-first framing
        re0 = re_count;
        begin_frame();
        do_read(16'h0100, 1'b1, 4, "R7 R1 magic word");
        end_frame();
        begin_frame();
        do_read(16'h040C, 1'b1, 2, "R7 identifier word");
        end_frame();
        check(re_count == re0, "R7 no bus_re for ROM", 32'(re_count - re0), 32'h0);

        // chained burst write then burst reads in one frame
        re0 = re_count;
        begin_frame();
        do_write(16'h0020, 1'b1, 3, 32'h1234_5678, "R3 R4 burst write");
        do_read(16'h0020, 1'b1, 3, "R6 R3 chained read back");
        do_read(16'h0080, 1'b1, 1, "R10 untouched register");
        end_frame();
        check(re_count - re0 == 4, "R10 one bus_re per read slot", 32'(re_count - re0), 32'd4);

        // fixed address bursts
        begin_frame();
        do_write(16'h0040, 1'b0, 2, 32'hDEAD_0001, "R4 fixed address write");
        do_read(16'h0040, 1'b0, 2, "R4 fixed address read");
        end_frame();

        // ignored commands: bad opcode, zero counts, reserved bits set
        begin_frame();
        xfer(mk_cmd(4'hC, 16'h0030, 1'b1, 3), FILL, "R5 bad opcode slot");
        xfer(mk_cmd(4'hB, 16'h0030, 1'b1, 0), FILL, "R5 zero count write");
        xfer(mk_cmd(4'hA, 16'h0030, 1'b1, 0), FILL, "R5 zero count read");
        xfer(mk_cmd(4'hA, 16'h0020, 1'b1, 1) | 32'h0000_000F, FILL, "R2 reserved bits command");
        xfer(32'h0, model_rd(16'h0020), "R2 read with reserved bits set");
        do_read(16'h0024, 1'b1, 1, "R5 next word decoded as command");
        end_frame();

        // abort inside a write burst: partial second word is dropped
        begin_frame();
        xfer(mk_cmd(4'hB, 16'h0060, 1'b1, 3), FILL, "R8 filler on command slot");
        wq_a.push_back(32'h0060);
        wq_d.push_back(32'h7777_0001);
        wq_t.push_back("R9 write before abort");
        shadow[8'h18] = 32'h7777_0001;
        xfer(32'h7777_0001, FILL, "R8 filler on write slot");
        shift_word(32'h7777_0002, 16);
        sclk = 1'b0;
        end_frame();
        check(wq_a.size() == 0, "R9 pending writes after abort", 32'(wq_a.size()), 32'h0);
        check(miso == 1'b0, "R11 MISO low with chip select high", {31'h0, miso}, 32'h0);
        begin_frame();
        do_read(16'h0060, 1'b1, 2, "R9 state after aborted burst");
        end_frame();

        check(exp_d.size() == 0, "R6 MISO expectations left", 32'(exp_d.size()), 32'h0);
        check(wq_a.size() == 0, "R3 write expectations left", 32'(wq_a.size()), 32'h0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule